// File: doc/BRIEF.md
# Banked Sound Register Window

This block sits on a CPU memory bus inside a cartridge address space and gives the CPU access to the registers of a five-channel wavetable tone generator. A six-bit bank register is loaded by any write in the 9000h–97FFh range. When that register holds 3Fh, the page 9800h–9FFFh stops being ROM and becomes the sound register window. Address lines 8 to 10 are not decoded, so the window's 256-byte page repeats eight times.

Inside the window, the lower half of the page is 128 bytes of waveform RAM (four 32-byte tables) that the CPU can read and write. The upper half holds write-only controls: five 12-bit tone periods, five 4-bit volumes, a five-bit channel enable mask and a single eight-bit test register. Every read in the upper half returns FFh. A read in the test range also loads FFh into the test register. The tone generator takes the register values straight from the output ports. It reads the waveform tables through a second, combinational read port, and it gets a one-cycle strobe for each channel whose period was written. For reads that do not hit the window, a ROM-select output tells the system to take the data from external ROM.

Top module: `snd_regbank`

## Requirements
- R1: Any write with address[15:11] = 10010b (9000h–97FFh) loads data bits 5:0 into the bank register. Data bits 7:6 are ignored. The bank register resets to 0.
- R2: The window is open only while the bank register equals 3Fh and address[15:11] = 10011b. rom_sel is high during a read (cs and rd) that misses the window and low at all other times. Writes to 9800h–9FFFh while the window is closed change nothing.
- R3: Address bits 10:8 are ignored inside the window, so 9800h+n and 9X00h+n reach the same location for any X from 8 to F.
- R4: Offsets 00h–7Fh are waveform RAM. Offset bits 6:5 select the table and bits 4:0 select the sample. A read returns the stored byte. gen_wave_data shows the byte at gen_wave_addr combinationally.
- R5: For channel c (0..4), offset 80h+2c writes bits 7:0 of its period and offset 81h+2c writes bits 11:8 from data bits 3:0. Period c sits in period_o[12c+11:12c]. Each period write pulses period_wr[c] for one cycle, together with the new value.
- R6: Offsets 8Ah+c write the 4-bit volume of channel c from data bits 3:0 into vol_o[4c+3:4c]. Offset 8Fh writes enable_o from data bits 4:0, with bit 0 for channel 0.
- R7: Offsets 90h–9Fh act exactly as 80h–8Fh. Writes to A0h–DFh change no output.
- R8: Every offset in E0h–FFh writes the one test register, shown on test_o. Its reset value is 0.
- R9: A window read at any offset 80h–FFh returns FFh. A window read at E0h–FFh also sets test_o to FFh.
- R10: rdata is registered. It changes only on a read and is valid on the cycle after the read. A read that misses the window returns 00h. rdata resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Bus cycle select for this cycle |
| rd | input | 1 | Read enable |
| wr | input | 1 | Write enable |
| addr | input | 16 | CPU address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rom_sel | output | 1 | Take read data from external ROM |
| gen_wave_addr | input | 7 | Generator waveform read address |
| gen_wave_data | output | 8 | Generator waveform sample |
| period_o | output | 60 | Five packed 12-bit periods |
| period_wr | output | 5 | Per-channel period write strobe |
| vol_o | output | 20 | Five packed 4-bit volumes |
| enable_o | output | 5 | Channel enable mask |
| test_o | output | 8 | Test register |

## Verification
Three kinds of result have three different due times. rom_sel and gen_wave_data are combinational, so they are checked a moment after the inputs are driven, in the same cycle. rdata, the register outputs and period_wr all come from the clock edge that takes the access, so they are checked at the falling edge after that edge. That is also the one cycle in which period_wr must be high. Inputs are driven and outputs sampled only on falling edges, so each check falls exactly one register stage after its stimulus, and the test register's set-on-read is checked at that same point.

// File: rtl/snd_regbank_pkg.sv
package snd_regbank_pkg;

   // fixed cartridge address map (upper five address bits)
   localparam logic [4:0] BANK_PAGE = 5'b10010;  // 9000h-97FFh
   localparam logic [4:0] WIN_PAGE  = 5'b10011;  // 9800h-9FFFh

   typedef enum logic [1:0] {
      RG_WAVE = 2'd0,
      RG_CTRL = 2'd1,
      RG_NONE = 2'd2,
      RG_TEST = 2'd3
   } region_e;

   function automatic region_e region_of(input logic [7:0] off);
      if (!off[7])              return RG_WAVE;
      else if (off[6:5] == 2'b00) return RG_CTRL;
      else if (off[6:5] == 2'b11) return RG_TEST;
      else                      return RG_NONE;
   endfunction

endpackage

// File: rtl/snd_bank_decode.sv
module snd_bank_decode
   import snd_regbank_pkg::*;
#(
   parameter int unsigned BANK_W   = 6,
   parameter logic [BANK_W-1:0] BANK_KEY = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              wr,
   input  logic [15:0]       addr,
   input  logic [7:0]        wdata,
   output logic [BANK_W-1:0] bank_q,
   output logic              win_hit,
   output logic [7:0]        off,
   output region_e           region
);

   logic bank_we;
   logic unused_bits;

   assign bank_we     = cs && wr && (addr[15:11] == BANK_PAGE);
   assign win_hit     = (bank_q == BANK_KEY) && (addr[15:11] == WIN_PAGE);
   assign off         = addr[7:0];
   assign region      = region_of(addr[7:0]);
   assign unused_bits = ^{addr[10:8], wdata[7:BANK_W]};

   always_ff @(posedge clk) begin
      if (!rst_n)       bank_q <= '0;
      else if (bank_we) bank_q <= wdata[BANK_W-1:0];
   end

endmodule

// File: rtl/snd_wave_ram.sv
module snd_wave_ram #(
   parameter int unsigned DEPTH = 128,
   parameter int unsigned AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] bus_addr,
   input  logic [7:0]    wdata,
   output logic [7:0]    bus_rdata,
   input  logic [AW-1:0] gen_addr,
   output logic [7:0]    gen_rdata
);

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
      end else if (we) begin
         mem[bus_addr] <= wdata;
      end
   end

   assign bus_rdata = mem[bus_addr];
   assign gen_rdata = mem[gen_addr];

endmodule

// File: rtl/snd_ctrl_regs.sv
module snd_ctrl_regs #(
   parameter int unsigned NUM_CH = 5,
   parameter int unsigned PER_W  = 12,
   parameter int unsigned VOL_W  = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ctrl_we,
   input  logic                      test_we,
   input  logic                      test_rd,
   input  logic [3:0]                idx,
   input  logic [7:0]                wdata,
   output logic [NUM_CH*PER_W-1:0]   period_o,
   output logic [NUM_CH-1:0]         period_wr,
   output logic [NUM_CH*VOL_W-1:0]   vol_o,
   output logic [NUM_CH-1:0]         enable_o,
   output logic [7:0]                test_o
);

   localparam int unsigned VOL_BASE = 2 * NUM_CH;
   localparam int unsigned EN_IDX   = 3 * NUM_CH;
   localparam int unsigned HI_W     = PER_W - 8;

   for (genvar c = 0; c < int'(NUM_CH); c++) begin : g_ch
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            period_o[c*PER_W +: PER_W] <= '0;
            vol_o[c*VOL_W +: VOL_W]    <= '0;
            period_wr[c]               <= 1'b0;
         end else begin
            period_wr[c] <= 1'b0;
            if (ctrl_we && idx == 4'(2*c)) begin
               period_o[c*PER_W +: 8] <= wdata;
               period_wr[c]           <= 1'b1;
            end
            if (ctrl_we && idx == 4'(2*c+1)) begin
               period_o[c*PER_W+8 +: HI_W] <= wdata[HI_W-1:0];
               period_wr[c]                <= 1'b1;
            end
            if (ctrl_we && idx == 4'(VOL_BASE+c))
               vol_o[c*VOL_W +: VOL_W] <= wdata[VOL_W-1:0];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enable_o <= '0;
         test_o   <= '0;
      end else begin
         if (ctrl_we && idx == 4'(EN_IDX)) enable_o <= wdata[NUM_CH-1:0];
         if (test_rd)      test_o <= 8'hFF;
         else if (test_we) test_o <= wdata;
      end
   end

endmodule

// File: rtl/snd_regbank.sv
module snd_regbank
   import snd_regbank_pkg::*;
#(
   parameter int unsigned NUM_CH      = 5,
   parameter int unsigned PER_W       = 12,
   parameter int unsigned VOL_W       = 4,
   parameter int unsigned WAVE_TABLES = 4,
   parameter int unsigned WAVE_LEN    = 32,
   parameter int unsigned BANK_W      = 6,
   parameter logic [BANK_W-1:0] BANK_KEY = 6'h3F,
   parameter int unsigned WAVE_AW     = $clog2(WAVE_TABLES*WAVE_LEN)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cs,
   input  logic                    rd,
   input  logic                    wr,
   input  logic [15:0]             addr,
   input  logic [7:0]              wdata,
   output logic [7:0]              rdata,
   output logic                    rom_sel,
   input  logic [WAVE_AW-1:0]      gen_wave_addr,
   output logic [7:0]              gen_wave_data,
   output logic [NUM_CH*PER_W-1:0] period_o,
   output logic [NUM_CH-1:0]       period_wr,
   output logic [NUM_CH*VOL_W-1:0] vol_o,
   output logic [NUM_CH-1:0]       enable_o,
   output logic [7:0]              test_o
);

   localparam int unsigned WAVE_DEPTH = WAVE_TABLES * WAVE_LEN;

   initial begin
      if (WAVE_DEPTH != 128)
         $fatal(1, "waveform area must fill offsets 00h-7Fh");
      if (PER_W < 9 || PER_W > 16)
         $fatal(1, "period must span two bytes");
      if (3*NUM_CH + 1 > 16 || VOL_W > 8 || NUM_CH > 8)
         $fatal(1, "control registers exceed the 16-byte block");
      if (BANK_W > 8)
         $fatal(1, "bank register wider than the data bus");
   end

   logic [BANK_W-1:0] bank_q;
   logic              win_hit;
   logic [7:0]        off;
   region_e           region;
   logic [7:0]        wave_bus_rd;
   logic              acc_wr, acc_rd;

   snd_bank_decode #(.BANK_W(BANK_W), .BANK_KEY(BANK_KEY)) u_dec (
      .clk, .rst_n, .cs, .wr, .addr, .wdata,
      .bank_q, .win_hit, .off, .region
   );

   assign acc_wr = cs && wr && win_hit;
   assign acc_rd = cs && rd && win_hit;

   snd_wave_ram #(.DEPTH(WAVE_DEPTH), .AW(WAVE_AW)) u_wave (
      .clk, .rst_n,
      .we        (acc_wr && region == RG_WAVE),
      .bus_addr  (off[WAVE_AW-1:0]),
      .wdata,
      .bus_rdata (wave_bus_rd),
      .gen_addr  (gen_wave_addr),
      .gen_rdata (gen_wave_data)
   );

   snd_ctrl_regs #(.NUM_CH(NUM_CH), .PER_W(PER_W), .VOL_W(VOL_W)) u_ctrl (
      .clk, .rst_n,
      .ctrl_we  (acc_wr && region == RG_CTRL),
      .test_we  (acc_wr && region == RG_TEST),
      .test_rd  (acc_rd && region == RG_TEST),
      .idx      (off[3:0]),
      .wdata,
      .period_o, .period_wr, .vol_o, .enable_o, .test_o
   );

   assign rom_sel = cs && rd && !win_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (cs && rd) begin
         if (!win_hit)               rdata <= 8'h00;
         else if (region == RG_WAVE) rdata <= wave_bus_rd;
         else                        rdata <= 8'hFF;
      end
   end

endmodule

// File: rtl/snd_regbank_chk.sv
module snd_regbank_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cs,
   input logic        rd,
   input logic        wr,
   input logic [15:0] addr,
   input logic [7:0]  wdata,
   input logic [7:0]  rdata,
   input logic        rom_sel,
   input logic [5:0]  bank_q,
   input logic [7:0]  test_o,
   input logic [11:0] per0,
   input logic [4:0]  period_wr,
   input logic [4:0]  enable_o
);

   logic win;
   logic unused_chk;
   assign win        = (bank_q == 6'h3F) && (addr[15:11] == 5'b10011);
   assign unused_chk = ^{addr[10:8], addr[4]};

   // R1
   a_r1_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
      cs && wr && addr[15:11] == 5'b10010 |=> bank_q == $past(wdata[5:0]));
   // R2
   a_r2_rom_sel: assert property (@(posedge clk) disable iff (!rst_n)
      cs && rd && bank_q != 6'h3F |-> rom_sel);
   // R9
   a_r9_ctrl_read_ff: assert property (@(posedge clk) disable iff (!rst_n)
      cs && rd && !wr && win && addr[7] |=> rdata == 8'hFF);
   // R9
   a_r9_test_set: assert property (@(posedge clk) disable iff (!rst_n)
      cs && rd && win && addr[7:5] == 3'b111 |=> test_o == 8'hFF);
   // R5
   a_r5_high_nibble: assert property (@(posedge clk) disable iff (!rst_n)
      cs && wr && win && addr[7:5] == 3'b100 && addr[3:0] == 4'd1
      |=> per0[11:8] == $past(wdata[3:0]));
   // R5
   a_r5_low_byte: assert property (@(posedge clk) disable iff (!rst_n)
      cs && wr && win && addr[7:5] == 3'b100 && addr[3:0] == 4'd0
      |=> per0[7:0] == $past(wdata));
   // R5
   a_r5_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(period_wr));
   // R6
   a_r6_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(cs && wr) |=> $stable(enable_o));

endmodule

bind snd_regbank snd_regbank_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs        (cs),
   .rd        (rd),
   .wr        (wr),
   .addr      (addr),
   .wdata     (wdata),
   .rdata     (rdata),
   .rom_sel   (rom_sel),
   .bank_q    (bank_q),
   .test_o    (test_o),
   .per0      (period_o[11:0]),
   .period_wr (period_wr),
   .enable_o  (enable_o)
);

// File: tb/snd_regbank_tb_top.sv
module snd_regbank_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs = 1'b0, rd = 1'b0, wr = 1'b0;
   logic [15:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic [7:0]  rdata;
   logic        rom_sel;
   logic [6:0]  gen_wave_addr = '0;
   logic [7:0]  gen_wave_data;
   logic [59:0] period_o;
   logic [4:0]  period_wr;
   logic [19:0] vol_o;
   logic [4:0]  enable_o;
   logic [7:0]  test_o;

   always #5ns clk = ~clk;

   snd_regbank dut_i (
      .clk, .rst_n, .cs, .rd, .wr, .addr, .wdata, .rdata, .rom_sel,
      .gen_wave_addr, .gen_wave_data, .period_o, .period_wr,
      .vol_o, .enable_o, .test_o
   );

   int unsigned n_cmp = 0, n_bad = 0;
   bit          done = 1'b0;

   // reference model
   logic [5:0]  m_bank;
   logic [7:0]  m_wave [128];
   logic [11:0] m_per  [5];
   logic [3:0]  m_vol  [5];
   logic [4:0]  m_en;
   logic [7:0]  m_test;

   task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   function automatic bit win_open(input logic [15:0] a);
      return (m_bank == 6'h3F) && (a[15:11] == 5'b10011);
   endfunction

   function automatic logic [7:0] exp_read(input logic [15:0] a);
      if (!win_open(a)) return 8'h00;
      if (a[7])         return 8'hFF;
      return m_wave[a[6:0]];
   endfunction

   function automatic logic [59:0] exp_per();
      logic [59:0] v;
      for (int c = 0; c < 5; c++) v[c*12 +: 12] = m_per[c];
      return v;
   endfunction

   function automatic logic [19:0] exp_vol();
      logic [19:0] v;
      for (int c = 0; c < 5; c++) v[c*4 +: 4] = m_vol[c];
      return v;
   endfunction

   task automatic model_reset();
      m_bank = '0; m_en = '0; m_test = '0;
      for (int i = 0; i < 128; i++) m_wave[i] = '0;
      for (int c = 0; c < 5; c++) begin m_per[c] = '0; m_vol[c] = '0; end
   endtask

   task automatic check_state(input string tag);
      check({tag, " R5 periods"}, 64'(period_o), 64'(exp_per()));
      check({tag, " R6 volumes"}, 64'(vol_o), 64'(exp_vol()));
      check({tag, " R6 enable"}, 64'(enable_o), 64'(m_en));
      check({tag, " R8 test"}, 64'(test_o), 64'(m_test));
      gen_wave_addr = 7'($urandom);
      #1;
      check({tag, " R4 gen port"}, 64'(gen_wave_data), 64'(m_wave[gen_wave_addr]));
   endtask

   // drive at falling edge; result due at the next falling edge
   task automatic do_write(input logic [15:0] a, input logic [7:0] d);
      logic [4:0] pw;
      cs = 1'b1; wr = 1'b1; rd = 1'b0; addr = a; wdata = d;
      @(negedge clk);
      cs = 1'b0; wr = 1'b0;
      pw = '0;
      if (a[15:11] == 5'b10010) begin
         m_bank = d[5:0];                                // R1
      end else if (win_open(a)) begin
         if (!a[7]) m_wave[a[6:0]] = d;                  // R4
         else if (a[6:5] == 2'b00) begin                 // R5 R6 R7
            int r = int'(a[3:0]);
            if (r < 10) begin
               if (r % 2 == 1) m_per[r/2][11:8] = d[3:0];
               else            m_per[r/2][7:0]  = d;
               pw[r/2] = 1'b1;
            end else if (r < 15) m_vol[r-10] = d[3:0];
            else                 m_en = d[4:0];
         end else if (a[6:5] == 2'b11) m_test = d;        // R8
      end
      check("R5 strobe", 64'(period_wr), 64'(pw));
      check_state("wr");
   endtask

   task automatic do_read(input logic [15:0] a);
      logic [7:0] exp;
      cs = 1'b1; rd = 1'b1; wr = 1'b0; addr = a;
      #1;
      check("R2 rom_sel", 64'(rom_sel), 64'(!win_open(a)));
      exp = exp_read(a);
      @(negedge clk);
      cs = 1'b0; rd = 1'b0;
      check("R10 R9 R4 rdata", 64'(rdata), 64'(exp));
      if (win_open(a) && a[7:5] == 3'b111) m_test = 8'hFF;  // R9
      check_state("rd");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      check("R10 reset rdata", 64'(rdata), 64'h0);
      check("R2 reset rom_sel", 64'(rom_sel), 64'h0);
      check_state("reset R8");

      // R2: window closed
      do_read(16'h9800);
      do_write(16'h9805, 8'h77);       // ignored while closed
      do_write(16'h9000, 8'hFF);       // R1: bits 7:6 ignored -> 3Fh
      do_read(16'h9805);               // still 00h: write was ignored
      // R3: mirror
      do_write(16'h9805, 8'h5A);
      do_read(16'h9F05);
      do_read(16'h9A05);
      // R5
      do_write(16'h9882, 8'h34);
      do_write(16'h9883, 8'hF7);
      // R6
      do_write(16'h988C, 8'hFA);
      do_write(16'h988F, 8'hFF);
      // R7
      do_write(16'h9891, 8'hC5);
      do_write(16'h98A5, 8'h99);
      do_write(16'h98DF, 8'h11);
      // R8 / R9
      do_write(16'h98E3, 8'h12);
      do_read(16'h98FF);
      do_write(16'h9BF0, 8'h00);
      do_read(16'h9880);
      do_read(16'h98B0);
      // R1 non-key value closes window
      do_write(16'h97FF, 8'h3E);
      do_read(16'h9805);
      do_write(16'h9123, 8'h7F);

      // constrained random
      for (int i = 0; i < 600; i++) begin
         int unsigned pick = $urandom % 100;
         logic [15:0] a;
         logic [7:0]  off;
         if (pick < 6) begin
            logic [7:0] d = ($urandom % 4 == 0) ? 8'($urandom)
                                                : (8'h3F | 8'(($urandom % 4) << 6));
            do_write({5'b10010, 11'($urandom)}, d);
         end else begin
            case ($urandom % 8)
               0, 1, 2, 3: off = {1'b0, 7'($urandom)};
               4, 5:       off = {3'b100, 5'($urandom)};
               6:          off = 8'hA0 + 8'($urandom % 64);
               default:    off = {3'b111, 5'($urandom)};
            endcase
            a = {5'b10011, 3'($urandom), off};
            if ($urandom % 2 == 0) do_write(a, 8'($urandom));
            else                   do_read(a);
         end
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule